// File: doc/BRIEF.md
# Segmented Instruction Prefetch Queue

This block is the fetch front end of a 16-bit processor core. It holds a code segment and a fetch offset and forms each 20-bit physical fetch address by adding the segment, moved up four bit positions, to the offset. It reads 16-bit words from memory through a request/acknowledge/response handshake. The fetched bytes go into a six-byte queue, and the execution side takes them one at a time over a valid/ready pair. Fetching and consumption run at the same time, so the queue refills while it drains.

A read counts as accepted in a cycle where `mem_req_o` and `mem_ack_i` are both high. Its response arrives in a later cycle with `mem_rvalid_i` high. A redirect pulse loads a new segment and offset, empties the queue and restarts fetching from there. Any response still owed to an earlier read is discarded.

Top module: `seg_prefetch_queue`

## Requirements
- R1: `mem_addr_o` equals (segment * 16 + offset) mod 2^20 with bit 0 forced to 0, so every read is word aligned.
- R2: Bytes leave the queue in ascending offset order and equal memory contents; in a returned word, bits [7:0] hold the byte at the even address and bits [15:8] the byte at the odd address.
- R3: The queue holds at most 6 bytes; a read is requested only while at least 2 bytes are free, so a full queue raises no request.
- R4: When the fetch offset is odd, only `mem_rdata_i[15:8]` is queued, the offset advances by 1, and the next read starts on an even offset.
- R5: A redirect empties the queue: `out_valid_o` is low in the cycle after `redir_i`.
- R6: The response to a read accepted before or in the same cycle as a redirect is discarded, and no new read is requested until that response has returned.
- R7: With no read in flight, a read at the new segment and offset is requested in the cycle after the redirect.
- R8: The fetch offset wraps within 16 bits (0xFFFF is followed by 0x0000) and the segment does not change.
- R9: At most one read is outstanding, and an unacknowledged request keeps the same address until it is accepted or a redirect occurs.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `out_byte_o` stays stable.
- R11: After reset the queue is empty and fetching starts at segment 0xFFFF, offset 0x0000, which gives request address 0xFFFF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| redir_i | input | 1 | Flush and restart at the new segment and offset |
| redir_seg_i | input | 16 | New code segment |
| redir_off_i | input | 16 | New fetch offset |
| mem_req_o | output | 1 | Word read request |
| mem_addr_o | output | 20 | Word-aligned physical read address |
| mem_ack_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 16 | Read data word |
| out_valid_o | output | 1 | Queue head byte valid |
| out_byte_o | output | 8 | Queue head byte |
| out_ready_i | input | 1 | Consumer takes the head byte |

## Verification
A redirect registered at one rising edge shows its new request address and an empty queue just after that edge. The bench therefore checks these one time unit after the edge. A response accepted at an edge makes its byte visible after that same edge, and a byte handshake completes at the edge that follows the falling edge where valid and ready were seen together. The monitor samples outputs and sets ready only on falling edges, and it drops ready during a redirect cycle, so each comparison falls in the cycle the byte is due. The memory model grants and answers with varying latency, and it flags any request made while a response is still owed.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
  localparam int unsigned SEG_W   = 16;
  localparam int unsigned OFF_W   = 16;
  localparam int unsigned SHIFT   = 4;
  localparam int unsigned ADDR_W  = 20;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned Q_DEPTH = 6;

  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/sfq_phys_addr.sv
module sfq_phys_addr
  import sfq_pkg::*;
(
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] phys_o
);
  // sum truncates to ADDR_W, so it wraps modulo 2^ADDR_W
  assign phys_o = ADDR_W'({seg_i, {SHIFT{1'b0}}}) + ADDR_W'(off_i);
endmodule

// File: rtl/sfq_byte_queue.sv
module sfq_byte_queue
  import sfq_pkg::*;
#(
  parameter int unsigned DEPTH = Q_DEPTH,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             push_two_i,
  input  byte_t            push_lo_i,
  input  byte_t            push_hi_i,
  input  logic             pop_i,
  output byte_t            head_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] count_o
);
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q, wr_nxt;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] push_n;
  logic             do_pop;
  byte_t            mem_q [DEPTH];

  function automatic logic [PTR_W-1:0] inc_ptr(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_nxt  = inc_ptr(wr_ptr_q);
  assign do_pop  = pop_i && (count_q != '0);
  assign push_n  = push_i ? (push_two_i ? CNT_W'(2) : CNT_W'(1)) : '0;
  assign head_o  = mem_q[rd_ptr_q];
  assign valid_o = (count_q != '0);
  assign count_o = count_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[i] <= '0;
      end else if (push_i && !flush_i) begin
        if (wr_ptr_q == PTR_W'(i))                     mem_q[i] <= push_lo_i;
        else if (push_two_i && wr_nxt == PTR_W'(i))    mem_q[i] <= push_hi_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_pop) rd_ptr_q <= inc_ptr(rd_ptr_q);
      if (push_i) wr_ptr_q <= push_two_i ? inc_ptr(wr_nxt) : wr_nxt;
      count_q <= count_q + push_n - CNT_W'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !flush_i) |-> (32'(count_q) + 32'(push_n) <= 32'(DEPTH) + 32'(do_pop))); // R3
endmodule

// File: rtl/sfq_fetch_ctrl.sv
module sfq_fetch_ctrl
  import sfq_pkg::*;
#(
  parameter int unsigned  DEPTH   = Q_DEPTH,
  parameter logic [15:0]  RST_SEG = 16'hFFFF,
  parameter logic [15:0]  RST_OFF = 16'h0000,
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              redir_i,
  input  logic [SEG_W-1:0]  redir_seg_i,
  input  logic [OFF_W-1:0]  redir_off_i,
  input  logic [CNT_W-1:0]  q_count_i,
  input  logic              odd_i,
  input  logic              mem_ack_i,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              mem_req_o,
  output logic [SEG_W-1:0]  fetch_seg_o,
  output logic [OFF_W-1:0]  fetch_off_o,
  output logic              push_o,
  output logic              push_two_o,
  output byte_t             push_lo_o,
  output byte_t             push_hi_o
);
  logic [SEG_W-1:0] seg_q;
  logic [OFF_W-1:0] off_q;
  logic busy_q, drop_q, odd_q;
  logic space_ok, fire;

  assign space_ok    = 32'(q_count_i) + 2 <= 32'(DEPTH);
  assign mem_req_o   = !busy_q && !drop_q && space_ok;
  assign fire        = mem_req_o && mem_ack_i;
  assign fetch_seg_o = seg_q;
  assign fetch_off_o = off_q;

  // odd fetch keeps only the upper byte lane
  assign push_o      = mem_rvalid_i && busy_q && !redir_i;
  assign push_two_o  = !odd_q;
  assign push_lo_o   = odd_q ? mem_rdata_i[15:8] : mem_rdata_i[7:0];
  assign push_hi_o   = mem_rdata_i[15:8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q  <= RST_SEG;
      off_q  <= RST_OFF;
      busy_q <= 1'b0;
      drop_q <= 1'b0;
      odd_q  <= 1'b0;
    end else if (redir_i) begin
      seg_q  <= redir_seg_i;
      off_q  <= redir_off_i;
      busy_q <= 1'b0;
      drop_q <= ((busy_q || drop_q) && !mem_rvalid_i) || fire;
    end else begin
      if (fire) begin
        off_q  <= off_q + (odd_i ? OFF_W'(1) : OFF_W'(2));
        odd_q  <= odd_i;
        busy_q <= 1'b1;
      end
      if (mem_rvalid_i) begin
        busy_q <= 1'b0;
        drop_q <= 1'b0;
      end
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !redir_i) |=> !mem_req_o); // R9
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !redir_i) |=> (mem_req_o && $stable(off_q) && $stable(seg_q))); // R9
  AST_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redir_i && !busy_q && !drop_q && !fire) |=> mem_req_o); // R7
  AST_DROP_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redir_i && fire) |=> !mem_req_o); // R6
endmodule

// File: rtl/seg_prefetch_queue.sv
module seg_prefetch_queue
  import sfq_pkg::*;
#(
  parameter int unsigned  DEPTH   = Q_DEPTH,
  parameter logic [15:0]  RST_SEG = 16'hFFFF,
  parameter logic [15:0]  RST_OFF = 16'h0000,
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              redir_i,
  input  logic [SEG_W-1:0]  redir_seg_i,
  input  logic [OFF_W-1:0]  redir_off_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_byte_o,
  input  logic              out_ready_i
);
  logic [SEG_W-1:0]  fetch_seg;
  logic [OFF_W-1:0]  fetch_off;
  logic [ADDR_W-1:0] phys;
  logic [CNT_W-1:0]  q_count;
  logic              push, push_two;
  byte_t             push_lo, push_hi;

  sfq_phys_addr i_addr (
    .seg_i  (fetch_seg),
    .off_i  (fetch_off),
    .phys_o (phys)
  );

  sfq_fetch_ctrl #(.DEPTH(DEPTH), .RST_SEG(RST_SEG), .RST_OFF(RST_OFF)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .redir_i      (redir_i),
    .redir_seg_i  (redir_seg_i),
    .redir_off_i  (redir_off_i),
    .q_count_i    (q_count),
    .odd_i        (phys[0]),
    .mem_ack_i    (mem_ack_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_req_o    (mem_req_o),
    .fetch_seg_o  (fetch_seg),
    .fetch_off_o  (fetch_off),
    .push_o       (push),
    .push_two_o   (push_two),
    .push_lo_o    (push_lo),
    .push_hi_o    (push_hi)
  );

  sfq_byte_queue #(.DEPTH(DEPTH)) i_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (redir_i),
    .push_i     (push),
    .push_two_i (push_two),
    .push_lo_i  (push_lo),
    .push_hi_i  (push_hi),
    .pop_i      (out_ready_i),
    .head_o     (out_byte_o),
    .valid_o    (out_valid_o),
    .count_o    (q_count)
  );

  assign mem_addr_o = {phys[ADDR_W-1:1], 1'b0};

  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_i |=> !out_valid_o); // R5
  AST_HOLD_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !redir_i) |=> (out_valid_o && $stable(out_byte_o))); // R10
  AST_FULL_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(q_count) == 32'(DEPTH)) |-> !mem_req_o); // R3
endmodule

// File: tb/test_seg_prefetch_queue.sv
module test_seg_prefetch_queue;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        redir = 1'b0;
  logic [15:0] seg = '0, off = '0;
  logic        mem_req, mem_ack = 1'b0, mem_rvalid = 1'b0;
  logic [19:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [7:0]  out_byte;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag = "R2";
  int mem_mode = 0, rdy_mode = 0;
  logic [31:0] lf_mem = 32'h1, lf_mon = 32'hACE1;

  seg_prefetch_queue i_seg_prefetch_queue (
    .clk_i(clk), .rst_ni(rst_n), .redir_i(redir), .redir_seg_i(seg), .redir_off_i(off),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .out_valid_o(out_valid), .out_byte_o(out_byte), .out_ready_i(out_ready)
  );

  function automatic logic [7:0] mb(logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h5};
  endfunction

  function automatic logic [7:0] eb(logic [15:0] s, logic [15:0] o, int i);
    logic [15:0] oi = o + 16'(i);
    logic [19:0] p = {s, 4'h0} + {4'h0, oi};
    return mb(p);
  endfunction

  function automatic logic [31:0] step(logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // memory model: random grant, 1..4 cycle latency (mode 1: always grant, 5 cycles)
  int cnt = 0;
  logic [19:0] ra = '0;
  always @(negedge clk) begin
    lf_mem = step(lf_mem);
    mem_rvalid = 1'b0;
    mem_ack = 1'b0;
    if (!rst_n) cnt = 0;
    else begin
      if (mem_req) chk(cnt == 0, "R9", 32'(cnt), 0);
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata = {mb(ra + 20'd1), mb(ra)};
        end
      end
      if (mem_req && (mem_mode == 1 || lf_mem[3])) begin
        mem_ack = 1'b1;
        ra = mem_addr;
        chk(mem_addr[0] == 1'b0, "R1", 32'(mem_addr), 32'(mem_addr & 20'hFFFFE));
        cnt = (mem_mode == 1) ? 5 : 1 + int'(lf_mem[5:4]);
      end
    end
  end

  // monitor: owns ready, pops expected bytes on each handshake (R10 via stalls)
  always @(negedge clk) begin
    logic [7:0] e;
    lf_mon = step(lf_mon);
    out_ready = rst_n && !redir && (exp_q.size() > 0) && (rdy_mode == 0 || lf_mon[2]);
    if (out_ready && out_valid) begin
      e = exp_q.pop_front();
      chk(out_byte == e, tag, 32'(out_byte), 32'(e));
    end
  end

  task automatic drain();
    while (exp_q.size() > 0) @(posedge clk);
    #1;
  endtask

  task automatic pulse(logic [15:0] s, logic [15:0] o);
    @(posedge clk); #1;
    redir = 1'b1; seg = s; off = o;
    @(posedge clk); #1;
    redir = 1'b0;
  endtask

  task automatic stream(logic [15:0] s, logic [15:0] o, int n, string t);
    @(posedge clk); #1;
    redir = 1'b1; seg = s; off = o; tag = t;
    for (int i = 0; i < n; i++) exp_q.push_back(eb(s, o, i));
    @(posedge clk); #1;
    redir = 1'b0;
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(out_valid == 1'b0, "R11", 32'(out_valid), 0);
    chk(mem_req == 1'b1, "R11", 32'(mem_req), 1);
    chk(mem_addr == 20'hFFFF0, "R11", 32'(mem_addr), 32'h FFFF0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R3: unconsumed queue fills, then requests stop
    repeat (40) @(posedge clk); #1;
    chk(mem_req == 1'b0, "R3", 32'(mem_req), 0);
    chk(out_valid == 1'b1, "R3", 32'(out_valid), 1);

    // R7/R1/R5: directed redirect to an odd offset at the top of memory
    @(posedge clk); #1;
    redir = 1'b1; seg = 16'hF000; off = 16'hFFFF;
    @(posedge clk); #1;
    redir = 1'b0;
    chk(mem_req == 1'b1, "R7", 32'(mem_req), 1);
    chk(mem_addr == 20'hFFFFE, "R1", 32'(mem_addr), 32'hFFFFE);
    chk(out_valid == 1'b0, "R5", 32'(out_valid), 0);
    tag = "R8";
    for (int i = 0; i < 10; i++) exp_q.push_back(eb(16'hF000, 16'hFFFF, i));
    drain();

    stream(16'h1234, 16'h0100, 40, "R2");
    rdy_mode = 1;
    stream(16'h0400, 16'h0057, 24, "R4");
    stream(16'hFFFF, 16'h0010, 16, "R1");
    stream(16'h2000, 16'hFFFE, 12, "R8");
    stream(16'h0ABC, 16'h7FF1, 30, "R10");
    rdy_mode = 0;

    // R6: redirect with a read in flight, then again back to back
    mem_mode = 1;
    pulse(16'h3000, 16'h0000);
    repeat (2) @(posedge clk);
    stream(16'h5000, 16'h0020, 16, "R6");
    pulse(16'h6000, 16'h0001);
    stream(16'h7000, 16'h0003, 16, "R6");
    mem_mode = 0;
    rdy_mode = 1;
    stream(16'h0000, 16'h0000, 20, "R2");

    // R3: full again after stop consuming
    repeat (40) @(posedge clk); #1;
    chk(mem_req == 1'b0, "R3", 32'(mem_req), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected=0", exp_q.size());
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule